// File: doc/BRIEF.md
# Programming-Enable Synchronisation Sequencer

This block is the host-side master that brings a target device into its serial programming mode. After a start request it holds the serial clock low, gives the target reset line a short positive pulse, and waits a settling interval. It then clocks out a four-byte enable instruction (0xAC, 0x53, 0x00, 0x00, most significant bit first) on MOSI while reading MISO back from the target.

A target that is in step with the host returns the second instruction byte (0x53) while the host sends the third byte. When that echo arrives, the block finishes with success. It then leaves the target reset low and the serial clock idle low. When the echo is wrong, the block still finishes the instruction. It then inserts a single extra clock pulse, which moves the target's bit framing by one position, and sends the whole instruction again. After a fixed number of failed attempts it reports that no device is present.

The serial clock is produced by a divider that holds each phase for `HALF_CYC` system cycles. The reset pulse width, the settling delay and the attempt limit are parameters counted in cycles or attempts.

Top module: `pe_sync_seq`

## Requirements
- R1: After reset and before any start, tgt_rst, sck, mosi, done, ok and fail are all 0 and no sck edge occurs.
- R2: A start in the idle or done state drives tgt_rst high for exactly RST_PULSE cycles, and sck stays 0 while tgt_rst is high.
- R3: After tgt_rst falls, no rising sck edge occurs for at least SETTLE_CYC cycles.
- R4: Every high phase of sck lasts at least HALF_CYC cycles (HALF_CYC >= 3). Every low phase between two rising edges also lasts at least HALF_CYC cycles.
- R5: Each attempt presents the 32-bit word 0xAC530000 on mosi, most significant bit first, one bit per sck pulse. mosi is stable across every rising sck edge.
- R6: miso is sampled in the last cycle of each sck high phase. The 8 bits sampled during the third byte (instruction bits 16 to 23, first sampled bit as the most significant) are compared with 0x53.
- R7: Every attempt gives exactly 32 rising sck edges for the instruction, whether or not the echo matched.
- R8: After a mismatch that is not the last allowed attempt, exactly one extra sck pulse with mosi at 0 follows, and then the full instruction is sent again. A run that succeeds on attempt n therefore gives 33*n-1 rising edges.
- R9: When the echo fails on attempt MAX_TRY (32), done and fail rise, ok stays 0, and no extra pulse is given. The run has 32*32+31 = 1055 rising edges.
- R10: On a match, done and ok rise, fail stays 0, and tgt_rst and sck stay 0 with no further sck edge while done holds.
- R11: start is ignored while a run is in progress, so the outcome and the edge count do not change. A start while done is high clears done, ok and fail on the next cycle and begins a new run.
- R12: A match on the final allowed attempt reports ok, not fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (acted on in idle or done state) |
| miso | input | 1 | Serial data from the target |
| tgt_rst | output | 1 | Target reset line (high during the reset pulse) |
| sck | output | 1 | Generated serial clock |
| mosi | output | 1 | Serial data to the target |
| done | output | 1 | Run finished |
| ok | output | 1 | Echo matched; target in programming mode |
| fail | output | 1 | Attempt limit reached without a match |

## Verification
Two decisions can fall in the same cycle. One is the echo match and the other is the attempt limit, when the target only comes into step on the last allowed attempt. The bench provokes this by starting the target model with a framing offset of one bit, so that only the 32nd attempt is aligned. The run is judged correct when ok is set, fail stays 0, and exactly 1055 rising edges were counted. A target stuck high reaches the same limit with the same edge count, and that run must end in fail.

// File: rtl/pe_pkg.sv
`timescale 1ns/1ps
package pe_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_RSTP, ST_SETTLE, ST_BLO, ST_BHI,
    ST_EVAL, ST_XLO, ST_XHI, ST_DONE
  } pe_state_t;

  localparam int          PE_BITS     = 32;
  localparam logic [31:0] PE_WORD     = 32'hAC53_0000;
  localparam logic [7:0]  PE_ECHO     = 8'h53;
  localparam int          PE_ECHO_END = 23;
endpackage

// File: rtl/pe_phase_div.sv
`timescale 1ns/1ps
module pe_phase_div #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic ph_end
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    ph_end = run && (cnt_q == CW'(HALF_CYC - 1));
    if (!run || ph_end) cnt_d = '0;
    else                cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pe_countdown.sv
`timescale 1ns/1ps
module pe_countdown #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    zero = (cnt_q == '0);
    if (load)       cnt_d = load_val;
    else if (!zero) cnt_d = cnt_q - 1'b1;
    else            cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pe_frame_shift.sv
`timescale 1ns/1ps
module pe_frame_shift
  import pe_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic shift,
  input  logic miso_in,
  output logic tx_bit,
  output logic last_bit,
  output logic echo_hit
);
  localparam int BW = $clog2(PE_BITS);

  logic [PE_BITS-1:0] tx_q, tx_d;
  logic [7:0]         rx_q, rx_d;
  logic [BW-1:0]      bc_q, bc_d;
  logic               hit_q, hit_d;

  always_comb begin
    tx_d  = tx_q;
    rx_d  = rx_q;
    bc_d  = bc_q;
    hit_d = hit_q;
    if (load) begin
      tx_d  = PE_WORD;
      bc_d  = '0;
      hit_d = 1'b0;
    end else if (shift) begin
      tx_d = {tx_q[PE_BITS-2:0], 1'b0};
      rx_d = {rx_q[6:0], miso_in};
      bc_d = bc_q + 1'b1;
      if (bc_q == BW'(PE_ECHO_END)) hit_d = ({rx_q[6:0], miso_in} == PE_ECHO);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      rx_q  <= '0;
      bc_q  <= '0;
      hit_q <= 1'b0;
    end else begin
      tx_q  <= tx_d;
      rx_q  <= rx_d;
      bc_q  <= bc_d;
      hit_q <= hit_d;
    end
  end

  assign tx_bit   = tx_q[PE_BITS-1];
  assign last_bit = (bc_q == BW'(PE_BITS - 1));
  assign echo_hit = hit_q;
endmodule

// File: rtl/pe_sync_seq.sv
`timescale 1ns/1ps
module pe_sync_seq
  import pe_pkg::*;
#(
  parameter int HALF_CYC   = 4,
  parameter int RST_PULSE  = 4,
  parameter int SETTLE_CYC = 4000000,
  parameter int MAX_TRY    = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic miso,
  output logic tgt_rst,
  output logic sck,
  output logic mosi,
  output logic done,
  output logic ok,
  output logic fail
);
  localparam int TMAX = (SETTLE_CYC > RST_PULSE) ? SETTLE_CYC : RST_PULSE;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int RW   = $clog2(MAX_TRY + 1);

  pe_state_t     st_q, st_d;
  logic [RW-1:0] try_q, try_d;
  logic          ok_q, ok_d, fail_q, fail_d;
  logic          tmr_ld, tmr_zero, fr_ld, fr_sh;
  logic [TW-1:0] tmr_val;
  logic          run, ph_end, tx_bit, last_bit, echo_hit;

  assign run = (st_q == ST_BLO) || (st_q == ST_BHI) ||
               (st_q == ST_XLO) || (st_q == ST_XHI);

  pe_phase_div #(.HALF_CYC(HALF_CYC)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .ph_end(ph_end)
  );

  pe_countdown #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_ld), .load_val(tmr_val), .zero(tmr_zero)
  );

  pe_frame_shift u_frm (
    .clk(clk), .rst_n(rst_n), .load(fr_ld), .shift(fr_sh), .miso_in(miso),
    .tx_bit(tx_bit), .last_bit(last_bit), .echo_hit(echo_hit)
  );

  always_comb begin
    st_d    = st_q;
    try_d   = try_q;
    ok_d    = ok_q;
    fail_d  = fail_q;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    fr_ld   = 1'b0;
    fr_sh   = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_DONE: if (start) begin
        st_d    = ST_RSTP;
        tmr_ld  = 1'b1;
        tmr_val = TW'(RST_PULSE - 1);
        try_d   = '0;
        ok_d    = 1'b0;
        fail_d  = 1'b0;
      end
      ST_RSTP: if (tmr_zero) begin
        st_d    = ST_SETTLE;
        tmr_ld  = 1'b1;
        tmr_val = TW'(SETTLE_CYC - 1);
      end
      ST_SETTLE: if (tmr_zero) begin
        st_d  = ST_BLO;
        fr_ld = 1'b1;
      end
      ST_BLO: if (ph_end) st_d = ST_BHI;
      ST_BHI: if (ph_end) begin
        fr_sh = 1'b1;
        st_d  = last_bit ? ST_EVAL : ST_BLO;
      end
      ST_EVAL: begin
        if (echo_hit) begin
          st_d = ST_DONE;
          ok_d = 1'b1;
        end else if (try_q == RW'(MAX_TRY - 1)) begin
          st_d   = ST_DONE;
          fail_d = 1'b1;
        end else begin
          try_d = try_q + 1'b1;
          st_d  = ST_XLO;
        end
      end
      ST_XLO: if (ph_end) st_d = ST_XHI;
      ST_XHI: if (ph_end) begin
        st_d  = ST_BLO;
        fr_ld = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      try_q  <= '0;
      ok_q   <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      try_q  <= try_d;
      ok_q   <= ok_d;
      fail_q <= fail_d;
    end
  end

  assign tgt_rst = (st_q == ST_RSTP);
  assign sck     = (st_q == ST_BHI) || (st_q == ST_XHI);
  assign mosi    = ((st_q == ST_BLO) || (st_q == ST_BHI)) && tx_bit;
  assign done    = (st_q == ST_DONE);
  assign ok      = ok_q;
  assign fail    = fail_q;
endmodule

// File: rtl/pe_sync_seq_chk.sv
`timescale 1ns/1ps
module pe_sync_seq_chk #(
  parameter int HALF_CYC = 4
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic tgt_rst,
  input logic sck,
  input logic mosi,
  input logic done,
  input logic ok,
  input logic fail
);
  localparam int CW = $clog2(HALF_CYC + 1) + 1;

  logic [CW-1:0] hi_run, lo_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0;
      lo_run <= CW'(HALF_CYC);
    end else begin
      if (sck) hi_run <= (hi_run < CW'(HALF_CYC)) ? hi_run + 1'b1 : hi_run;
      else     hi_run <= '0;
      if (!sck) lo_run <= (lo_run < CW'(HALF_CYC)) ? lo_run + 1'b1 : lo_run;
      else      lo_run <= '0;
    end
  end

  p_rst_sck_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_rst |-> !sck);
  p_hi_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck) |-> (hi_run >= CW'(HALF_CYC)));
  p_lo_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> (lo_run >= CW'(HALF_CYC)));
  p_mosi_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $stable(mosi));
  p_flag_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok && fail));
  p_flag_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ok || fail) |-> done);
  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!sck && !tgt_rst));
  p_done_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
endmodule

bind pe_sync_seq pe_sync_seq_chk #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .tgt_rst(tgt_rst), .sck(sck),
  .mosi(mosi), .done(done), .ok(ok), .fail(fail)
);

// File: tb/sim_pe_sync_seq.sv
`timescale 1ns/1ps
module sim_pe_sync_seq;
  localparam int HALF   = 3;
  localparam int RSTP   = 4;
  localparam int SETTLE = 200;
  localparam int TRIES  = 32;

  logic clk, rst_n, start, miso;
  logic tgt_rst, sck, mosi, done, ok, fail;

  int checks = 0;
  int fails  = 0;

  pe_sync_seq #(.HALF_CYC(HALF), .RST_PULSE(RSTP), .SETTLE_CYC(SETTLE), .MAX_TRY(TRIES)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .miso(miso), .tgt_rst(tgt_rst),
    .sck(sck), .mosi(mosi), .done(done), .ok(ok), .fail(fail)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // target model: bit position counter reset by the reset pulse, echo only when framed
  int unsigned tgt_off = 0;
  bit          tgt_stuck = 0;
  logic [4:0]  t_pos = '0;
  logic [7:0]  t_rx = '0, t_echo = '0;
  logic [31:0] t_frame = '0;
  int          rise_cnt = 0;

  always @(posedge tgt_rst) t_pos = tgt_off[4:0];
  always @(posedge sck) begin
    if (t_pos == 5'd15) t_echo = {t_rx[6:0], mosi};
    t_rx    = {t_rx[6:0], mosi};
    t_frame = {t_frame[30:0], mosi};
    t_pos   = t_pos + 5'd1;
    rise_cnt++;
  end
  always @(negedge sck) begin
    int k;
    k = 23 - int'(t_pos);
    if (!tgt_stuck && t_pos >= 5'd16 && t_pos <= 5'd23 && t_echo == 8'h53)
      miso = t_echo[k[2:0]];
    else
      miso = 1'b1;
  end

  // timing monitor sampled away from the active edge
  int rst_w, gap, hi_run, lo_run, min_hi, min_lo;
  bit seen_rst, seen_rise, p_sck;
  always @(negedge clk) begin
    if (tgt_rst) begin rst_w++; seen_rst = 1; end
    else if (seen_rst && !seen_rise && !sck) gap++;
    if (sck) begin
      if (!p_sck && seen_rise && lo_run < min_lo) min_lo = lo_run;
      if (!p_sck) seen_rise = 1;
      hi_run++; lo_run = 0;
    end else begin
      if (p_sck && hi_run < min_hi) min_hi = hi_run;
      lo_run++; hi_run = 0;
    end
    p_sck = sck;
  end

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_tries(input int off);
    return ((32 - off) % 32) + 1;
  endfunction

  function automatic int exp_rises(input int off, input bit stuck);
    if (stuck) return TRIES * 32 + (TRIES - 1);
    return 33 * exp_tries(off) - 1;
  endfunction

  task automatic run_case(input int off, input bit stuck, input bit inject);
    int n;
    int er;
    tgt_off = off; tgt_stuck = stuck;
    rise_cnt = 0; rst_w = 0; gap = 0; seen_rst = 0; seen_rise = 0;
    min_hi = 1000; min_lo = 1000; hi_run = 0; lo_run = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(!done && !ok && !fail, "R11 flags cleared on restart", {29'd0, done, ok, fail}, 0);
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
      start = inject && (n == 250);
    end
    start = 1'b0;
    chk(done, "R9/R10 run finishes", done, 1);
    repeat (20) @(negedge clk);
    er = exp_rises(off, stuck);
    chk(rst_w == RSTP, "R2 reset pulse width", rst_w, RSTP);
    chk(gap >= SETTLE, "R3 settle before first edge", gap, SETTLE);
    chk(min_hi >= HALF && min_lo >= HALF, "R4 minimum phase", (min_hi < min_lo) ? min_hi : min_lo, HALF);
    if (stuck) begin
      chk(fail && !ok, "R9 no device reported", {30'd0, ok, fail}, 1);
      chk(rise_cnt == er, "R9 edges without final extra pulse", rise_cnt, er);
    end else begin
      chk(ok && !fail, inject ? "R11 start ignored while busy" : "R6 echo matched", {30'd0, ok, fail}, 2);
      chk(rise_cnt == er, off == 0 ? "R7 32 edges per attempt" : "R8 extra pulse per retry", rise_cnt, er);
      chk(t_frame == 32'hAC53_0000, "R5 instruction word", int'(t_frame), int'(32'hAC53_0000));
      if (off == 1) chk(ok, "R12 match on last attempt", ok, 1);
    end
    chk(done && !sck && !tgt_rst, "R10 idle after done", {29'd0, done, sck, tgt_rst}, 4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd1234);
    rst_n = 1'b0; start = 1'b0; miso = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    chk(!tgt_rst && !sck && !mosi && !done && !ok && !fail, "R1 reset state",
        {26'd0, tgt_rst, sck, mosi, done, ok, fail}, 0);
    chk(rise_cnt == 0, "R1 no edge before start", rise_cnt, 0);

    run_case(0, 0, 0);   // aligned target: one attempt
    run_case(1, 0, 0);   // match only on attempt 32 (R12)
    run_case(0, 1, 0);   // no echo at all: fail
    run_case(5, 0, 1);   // start pulse mid-run ignored
    for (int i = 0; i < 5; i++) run_case(int'($urandom % 32), 0, 0);
    run_case(31, 0, 0);  // two attempts

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule